// File: doc/BRIEF.md
# System Mask Store-and-Modify Unit

This unit executes two privileged control instructions that act on the 8-bit system mask, the leading byte of the program status word. Each instruction first writes the mask byte as it stands to a byte address in memory. Only then does it replace the mask with a combination of the old mask and an 8-bit immediate. One opcode ANDs the mask with the immediate, which lets software clear chosen mask bits. The other opcode ORs the mask with the immediate, which lets software set chosen mask bits. In both cases the saved copy allows the original mask to be restored later.

The unit owns the mask register. It reads a base register through a small combinational read port and forms the byte address from that register and a 12-bit displacement. It then drives a byte write port and holds the write until the memory reports success or an error. Finally, it reports completion with an exception code and an instruction-length code.

The unit also handles three exception cases:
- A memory error suppresses the instruction.
- Problem state suppresses the instruction before any store.
- For the OR form only, a validity check runs on the mask after it has been loaded. The instruction still completes, but it raises a specification exception.

Top module: `sysmask_unit`

## Requirements
- R1: The instruction word is split MSB-first: opcode in bits 31:24, immediate in 23:16, base field in 15:12, displacement in 11:0. `gpr_sel` carries the base field. The store address is `gpr_val` plus the zero-extended displacement, modulo 2^ADDR_W. A base field of 0 uses zero in place of `gpr_val`.
- R2: The byte written (`mem_wdata`) is the system mask as it stood when the instruction was accepted, before any modification.
- R3: After a successful store, opcode 0xAC sets the mask to old mask AND immediate.
- R4: After a successful store, opcode 0xAD sets the mask to old mask OR immediate.
- R5: If the store ends with `mem_err`, the mask is unchanged. The exception code is 0x05 when `mem_err_prot` is 0 (addressing) and 0x04 when it is 1 (protection).
- R6: Consider opcode 0xAD with `ec_mode` high. If the new mask has any of `sys_mask[7]`, `sys_mask[5:2]` set, the new mask stays loaded, the exception code is 0x06, and `ilc` is 2. This check never applies to 0xAC, and never applies when `ec_mode` is low.
- R7: If `problem_state` is high when the instruction is accepted, no store is issued, the mask is unchanged, and the exception code is 0x02.
- R8: Every completion is a one-cycle `done` pulse with `ilc` = 2. `exc_valid` is high only together with `done`. A completion without an exception has `exc_valid` low.
- R9: An instruction with any opcode other than 0xAC or 0xAD is ignored: no store, no mask change, no `done`.
- R10: `insn_ready` is high only while idle. Once issued, `mem_wr_en` and `mem_addr` stay asserted and stable until `mem_ack` or `mem_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction presented |
| insn | input | 32 | Instruction word |
| insn_ready | output | 1 | Unit idle, instruction accepted this cycle |
| problem_state | input | 1 | CPU in problem (unprivileged) state |
| ec_mode | input | 1 | Extended-control PSW format active |
| gpr_sel | output | 4 | Base register index |
| gpr_val | input | ADDR_W | Contents of selected base register |
| mem_wr_en | output | 1 | Byte write request |
| mem_addr | output | ADDR_W | Byte write address |
| mem_wdata | output | 8 | Byte write data |
| mem_ack | input | 1 | Write completed |
| mem_err | input | 1 | Write failed |
| mem_err_prot | input | 1 | Failure is protection (1) or addressing (0) |
| sys_mask | output | 8 | Current system mask, bit 7 = PSW bit 0 |
| done | output | 1 | Instruction finished |
| exc_valid | output | 1 | Program exception raised |
| exc_code | output | 8 | Exception code |
| ilc | output | 2 | Instruction-length code |

## Verification
The mask commit and the specification exception arise from the same memory acknowledge. A correct OR instruction in EC mode must load the new mask and flag the exception in one completion; a design that drops either half fails.

The bench provokes this with immediates chosen so that the OR result sets bits from the checked group. It judges the `done` cycle on mask, exception code and stored byte together. It also runs control cases: the same mask pattern produced by AND, and the same pattern with EC mode off. Both controls must raise no exception.

// File: rtl/sysmask_pkg.sv
package sysmask_pkg;

   localparam logic [7:0] OPC_AND = 8'hAC;
   localparam logic [7:0] OPC_OR  = 8'hAD;

   localparam logic [7:0] EXC_PRIV = 8'h02;
   localparam logic [7:0] EXC_PROT = 8'h04;
   localparam logic [7:0] EXC_ADDR = 8'h05;
   localparam logic [7:0] EXC_SPEC = 8'h06;

   typedef enum logic {ST_IDLE, ST_STORE} sm_state_e;

   typedef struct packed {
      logic [7:0]  opcode;
      logic [7:0]  imm;
      logic [3:0]  base;
      logic [11:0] disp;
   } sm_insn_t;

   // Length code from the two leading opcode bits.
   function automatic logic [1:0] ilc_of(input logic [7:0] opc);
      case (opc[7:6])
         2'b00:   ilc_of = 2'd1;
         2'b11:   ilc_of = 2'd3;
         default: ilc_of = 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/sm_decode.sv
module sm_decode
   import sysmask_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input  logic [31:0]       insn,
   input  logic [ADDR_W-1:0] gpr_val,
   output logic [3:0]        gpr_sel,
   output logic              is_and,
   output logic              is_or,
   output logic [7:0]        imm,
   output logic [ADDR_W-1:0] ea,
   output logic [1:0]        ilc
);
   localparam int DISP_W = 12;

   sm_insn_t f;
   logic [ADDR_W-1:0] base_v;
   logic [ADDR_W-1:0] disp_x;

   assign f       = sm_insn_t'(insn);
   assign gpr_sel = f.base;
   assign imm     = f.imm;
   assign is_and  = (f.opcode == OPC_AND);
   assign is_or   = (f.opcode == OPC_OR);
   assign ilc     = ilc_of(f.opcode);

   // Base field zero means no base register.
   assign base_v = (f.base == 4'd0) ? '0 : gpr_val;

   generate
      if (ADDR_W > DISP_W) begin : g_wide
         assign disp_x = {{(ADDR_W-DISP_W){1'b0}}, f.disp};
      end else begin : g_exact
         assign disp_x = f.disp[ADDR_W-1:0];
      end
   endgenerate

   // R1: wraps modulo 2^ADDR_W
   assign ea = base_v + disp_x;

endmodule

// File: rtl/sm_mask_alu.sv
module sm_mask_alu #(
   parameter logic [7:0] SPEC_BITS     = 8'hBC,
   parameter bit         SPEC_CHECK_EN = 1'b1
) (
   input  logic [7:0] old_mask,
   input  logic [7:0] imm,
   input  logic       op_or,
   input  logic       ec_mode,
   output logic [7:0] new_mask,
   output logic       spec_hit
);
   assign new_mask = op_or ? (old_mask | imm) : (old_mask & imm);

   generate
      if (SPEC_CHECK_EN) begin : g_check
         // Checked after loading: only the OR form, only in EC mode.
         assign spec_hit = op_or && ec_mode && ((new_mask & SPEC_BITS) != 8'h00);
      end else begin : g_nocheck
         logic unused_ok;
         assign unused_ok = ec_mode;
         assign spec_hit  = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/sm_ctrl.sv
module sm_ctrl
   import sysmask_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_valid,
   input  logic              is_and,
   input  logic              is_or,
   input  logic              problem_state,
   input  logic [ADDR_W-1:0] ea,
   input  logic [7:0]        imm_in,
   input  logic [1:0]        ilc_in,
   input  logic [7:0]        cur_mask,
   input  logic              mem_ack,
   input  logic              mem_err,
   input  logic              mem_err_prot,
   input  logic              spec_hit,
   output logic              insn_ready,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              op_or,
   output logic [7:0]        imm_q,
   output logic              mask_we,
   output logic              done,
   output logic              exc_valid,
   output logic [7:0]        exc_code,
   output logic [1:0]        ilc
);
   sm_state_e state;
   logic      accept;

   assign insn_ready = (state == ST_IDLE);
   assign accept     = insn_ready && insn_valid && (is_and || is_or);
   assign mem_wr_en  = (state == ST_STORE);
   assign mask_we    = (state == ST_STORE) && mem_ack && !mem_err;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         mem_addr  <= '0;
         mem_wdata <= '0;
         op_or     <= 1'b0;
         imm_q     <= '0;
         done      <= 1'b0;
         exc_valid <= 1'b0;
         exc_code  <= '0;
         ilc       <= '0;
      end else begin
         done      <= 1'b0;
         exc_valid <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  op_or     <= is_or;
                  imm_q     <= imm_in;
                  ilc       <= ilc_in;
                  mem_addr  <= ea;
                  mem_wdata <= cur_mask;
                  if (problem_state) begin
                     done      <= 1'b1;
                     exc_valid <= 1'b1;
                     exc_code  <= EXC_PRIV;
                  end else begin
                     state <= ST_STORE;
                  end
               end
            end
            ST_STORE: begin
               if (mem_err) begin
                  state     <= ST_IDLE;
                  done      <= 1'b1;
                  exc_valid <= 1'b1;
                  exc_code  <= mem_err_prot ? EXC_PROT : EXC_ADDR;
               end else if (mem_ack) begin
                  state     <= ST_IDLE;
                  done      <= 1'b1;
                  exc_valid <= spec_hit;
                  exc_code  <= spec_hit ? EXC_SPEC : 8'h00;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R10: write request held stable until a response
   a_r10_wr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_en && !mem_ack && !mem_err) |=> (mem_wr_en && $stable(mem_addr) && $stable(mem_wdata)));

   // R8: an exception is only ever reported with completion
   a_r8_exc_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> done);

   // R8: completion is a single-cycle pulse
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done || $past(insn_valid));

   // R7: privileged fault never starts a store
   a_r7_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_ready && insn_valid && problem_state) |=> !mem_wr_en);

endmodule

// File: rtl/sysmask_unit.sv
module sysmask_unit #(
   parameter int          ADDR_W        = 24,
   parameter logic [7:0]  RESET_MASK    = 8'h00,
   parameter logic [7:0]  SPEC_BITS     = 8'hBC,
   parameter bit          SPEC_CHECK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_valid,
   input  logic [31:0]       insn,
   output logic              insn_ready,
   input  logic              problem_state,
   input  logic              ec_mode,
   output logic [3:0]        gpr_sel,
   input  logic [ADDR_W-1:0] gpr_val,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   input  logic              mem_err_prot,
   output logic [7:0]        sys_mask,
   output logic              done,
   output logic              exc_valid,
   output logic [7:0]        exc_code,
   output logic [1:0]        ilc
);
   initial begin
      assert (ADDR_W >= 12 && ADDR_W <= 64)
         else $error("sysmask_unit: ADDR_W out of range");
   end

   logic              is_and, is_or, op_or, mask_we, spec_hit;
   logic [7:0]        imm_d, imm_q, new_mask;
   logic [ADDR_W-1:0] ea;
   logic [1:0]        ilc_d;
   logic [7:0]        mask_q;

   sm_decode #(.ADDR_W(ADDR_W)) u_dec (
      .insn    (insn),
      .gpr_val (gpr_val),
      .gpr_sel (gpr_sel),
      .is_and  (is_and),
      .is_or   (is_or),
      .imm     (imm_d),
      .ea      (ea),
      .ilc     (ilc_d)
   );

   sm_mask_alu #(.SPEC_BITS(SPEC_BITS), .SPEC_CHECK_EN(SPEC_CHECK_EN)) u_alu (
      .old_mask (mask_q),
      .imm      (imm_q),
      .op_or    (op_or),
      .ec_mode  (ec_mode),
      .new_mask (new_mask),
      .spec_hit (spec_hit)
   );

   sm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .insn_valid    (insn_valid),
      .is_and        (is_and),
      .is_or         (is_or),
      .problem_state (problem_state),
      .ea            (ea),
      .imm_in        (imm_d),
      .ilc_in        (ilc_d),
      .cur_mask      (mask_q),
      .mem_ack       (mem_ack),
      .mem_err       (mem_err),
      .mem_err_prot  (mem_err_prot),
      .spec_hit      (spec_hit),
      .insn_ready    (insn_ready),
      .mem_wr_en     (mem_wr_en),
      .mem_addr      (mem_addr),
      .mem_wdata     (mem_wdata),
      .op_or         (op_or),
      .imm_q         (imm_q),
      .mask_we       (mask_we),
      .done          (done),
      .exc_valid     (exc_valid),
      .exc_code      (exc_code),
      .ilc           (ilc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= RESET_MASK;
      else if (mask_we) mask_q <= new_mask;
   end

   assign sys_mask = mask_q;

   // R2: the stored byte is the unmodified mask
   a_r2_wdata_old: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (mem_wdata == sys_mask));

   // R3: the AND form can only clear bits
   a_r3_and_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_en && mem_ack && !mem_err && !op_or) |=> ((sys_mask & ~$past(sys_mask)) == 8'h00));

   // R4: the OR form can only set bits
   a_r4_or_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_en && mem_ack && !mem_err && op_or) |=> ((sys_mask & $past(sys_mask)) == $past(sys_mask)));

   // R5: a failed store leaves the mask alone
   a_r5_err_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_en && mem_err) |=> $stable(sys_mask));

   // R9: outside a store the mask never moves
   a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr_en |=> $stable(sys_mask));

endmodule

// File: tb/sysmask_unit_tb.sv
module sysmask_unit_tb;
   localparam int ADDR_W = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic insn_valid = 1'b0;
   logic [31:0] insn = '0;
   logic insn_ready;
   logic problem_state = 1'b0, ec_mode = 1'b0;
   logic [3:0] gpr_sel;
   logic [ADDR_W-1:0] gpr_val;
   logic mem_wr_en;
   logic [ADDR_W-1:0] mem_addr;
   logic [7:0] mem_wdata;
   logic mem_ack = 1'b0, mem_err = 1'b0, mem_err_prot = 1'b0;
   logic [7:0] sys_mask;
   logic done, exc_valid;
   logic [7:0] exc_code;
   logic [1:0] ilc;

   always #2 clk = ~clk;

   sysmask_unit u_dut (
      .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
      .insn_ready(insn_ready), .problem_state(problem_state), .ec_mode(ec_mode),
      .gpr_sel(gpr_sel), .gpr_val(gpr_val), .mem_wr_en(mem_wr_en),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_err(mem_err), .mem_err_prot(mem_err_prot), .sys_mask(sys_mask),
      .done(done), .exc_valid(exc_valid), .exc_code(exc_code), .ilc(ilc)
   );

   logic [ADDR_W-1:0] gpr [16];
   assign gpr_val = gpr[gpr_sel];

   int n_vec = 0, n_bad = 0;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // responder model
   int   rsp_lat = 0;
   bit   rsp_err = 0, rsp_prot = 0;
   int   wait_cnt = 0;
   int   st_cnt = 0;
   logic [ADDR_W-1:0] st_addr;
   logic [7:0] st_data;

   always @(negedge clk) begin
      if (mem_ack || mem_err) begin
         mem_ack <= 1'b0; mem_err <= 1'b0;
      end else if (mem_wr_en) begin
         if (wait_cnt >= rsp_lat) begin
            wait_cnt = 0;
            st_cnt++;
            st_addr = mem_addr;
            st_data = mem_wdata;
            mem_err_prot <= rsp_prot;
            if (rsp_err) mem_err <= 1'b1; else mem_ack <= 1'b1;
         end else wait_cnt++;
      end
   end

   // scoreboard
   typedef struct {
      string req;
      logic [7:0] mask;
      bit exc_v;
      logic [7:0] code;
      int cnt;
      bit stored;
      logic [ADDR_W-1:0] addr;
      logic [7:0] data;
   } exp_t;
   exp_t q[$];
   int done_cnt = 0;

   always @(negedge clk) begin
      if (rst_n && done) begin
         done_cnt++;
         if (q.size() == 0) chk("R8", "unexpected done", 1, 0);
         else begin
            exp_t e;
            e = q.pop_front();
            chk(e.req, "mask", sys_mask, e.mask);
            chk(e.req, "exc_valid", exc_valid, e.exc_v);
            if (e.exc_v) chk(e.req, "exc_code", exc_code, e.code);
            chk("R8", "ilc", ilc, 2);
            chk(e.req, "store count", st_cnt, e.cnt);
            if (e.stored) begin
               chk("R1", "store addr", st_addr, e.addr);
               chk("R2", "store data", st_data, e.data);
            end
         end
      end
   end

   logic [7:0] m_mask = 8'h00;
   int m_cnt = 0;

   task automatic issue(input string req, input logic [7:0] opc, input logic [7:0] imm,
                        input logic [3:0] base, input logic [11:0] disp,
                        input bit ps, input bit ec, input int lat, input bit err, input bit prot);
      exp_t e;
      int dc;
      logic [7:0] nm;
      e.req = req; e.stored = 0; e.exc_v = 0; e.code = 8'h00;
      if (ps) begin
         e.exc_v = 1; e.code = 8'h02;
      end else begin
         e.stored = 1; m_cnt++;
         e.addr = ((base == 0) ? '0 : gpr[base]) + ADDR_W'(disp);
         e.data = m_mask;
         if (err) begin
            e.exc_v = 1; e.code = prot ? 8'h04 : 8'h05;
         end else begin
            nm = (opc == 8'hAD) ? (m_mask | imm) : (m_mask & imm);
            if (opc == 8'hAD && ec && ((nm & 8'hBC) != 0)) begin
               e.exc_v = 1; e.code = 8'h06;
            end
            m_mask = nm;
         end
      end
      e.mask = m_mask; e.cnt = m_cnt;
      q.push_back(e);
      @(negedge clk);
      while (!insn_ready) @(negedge clk);
      rsp_lat = lat; rsp_err = err; rsp_prot = prot;
      problem_state = ps; ec_mode = ec;
      dc = done_cnt;
      insn = {opc, imm, base, disp};
      insn_valid = 1'b1;
      @(negedge clk);
      insn_valid = 1'b0;
      while (done_cnt == dc) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) gpr[i] = ADDR_W'(i * 24'h100 + 24'h7);
      gpr[9] = 24'hFFFFF0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "reset mask", sys_mask, 8'h00);
      chk("R10", "reset ready", insn_ready, 1);
      chk("R10", "reset wr_en", mem_wr_en, 0);
      chk("R8", "reset done", done, 0);

      issue("R4", 8'hAD, 8'hFF, 4'd0, 12'h123, 0, 0, 0, 0, 0);  // 00 -> FF
      issue("R3", 8'hAC, 8'h0F, 4'd3, 12'h010, 0, 0, 1, 0, 0);  // FF -> 0F
      issue("R6", 8'hAD, 8'h40, 4'd2, 12'h004, 0, 1, 0, 0, 0);  // 0F -> 4F, spec
      issue("R6", 8'hAC, 8'hFF, 4'd0, 12'h008, 0, 1, 0, 0, 0);  // AND keeps 4F, no spec
      issue("R3", 8'hAC, 8'h43, 4'd0, 12'h00C, 0, 1, 2, 0, 0);  // 4F -> 43
      issue("R6", 8'hAD, 8'h01, 4'd1, 12'h020, 0, 1, 0, 0, 0);  // 43 clean, no spec
      issue("R6", 8'hAD, 8'h80, 4'd0, 12'h030, 0, 0, 0, 0, 0);  // C3, ec off
      issue("R5", 8'hAD, 8'h3C, 4'd0, 12'h040, 0, 1, 0, 1, 0);  // addressing
      issue("R5", 8'hAC, 8'h00, 4'd4, 12'h050, 0, 0, 3, 1, 1);  // protection
      issue("R7", 8'hAC, 8'h00, 4'd0, 12'h060, 1, 0, 0, 0, 0);  // problem state
      issue("R1", 8'hAC, 8'hF0, 4'd9, 12'h020, 0, 0, 4, 0, 0);  // wrap -> 0x10
      issue("R10", 8'hAD, 8'h3C, 4'd15, 12'hFFF, 0, 1, 5, 0, 0); // slow ack, spec

      begin
         int dc, sc;
         dc = done_cnt; sc = st_cnt;
         @(negedge clk);
         insn = {8'h80, 8'hFF, 4'd0, 12'h000};
         insn_valid = 1'b1;
         @(negedge clk);
         insn_valid = 1'b0;
         repeat (6) @(negedge clk);
         chk("R9", "no done", done_cnt, dc);
         chk("R9", "no store", st_cnt, sc);
         chk("R9", "mask kept", sys_mask, m_mask);
         chk("R9", "still ready", insn_ready, 1);
      end

      issue("R4", 8'hAD, 8'h00, 4'd0, 12'h000, 0, 0, 0, 0, 0);
      repeat (4) @(negedge clk);
      chk("R8", "queue drained", q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule